// File: doc/BRIEF.md
# Match Watchdog with Timed Reset Pulse

This block is a watchdog peripheral on a simple 32-bit register bus. A 32-bit up-counter advances on each cycle where the tick enable is high and counting is on. A debug-halt input can freeze it. When the counter reaches a programmed match value, the block can take any of these actions: set a match flag (optionally raising an interrupt), clear and stop the counter, move a match output pin, pulse an internal reset request, or start an active-low external reset pulse. The length of the external pulse is programmable.

Software can force either reset at once, with no match needed. A sticky cause flag records that the watchdog issued a reset. Only the power-on reset clears that flag, so boot software can read it after the system reset that the watchdog itself caused. The reset requests are plain outputs, and a system reset controller outside this block acts on them.

Top module: `match_watchdog`

## Requirements
- R1: After `rst_n` is low, every register other than the cause flag reads 0, `ext_rst_n` is 1, and `irq`, `match_out` and `int_rst_req` are 0. Registers sit at byte offsets 0x00 flag, 0x04 control, 0x08 counter, 0x0C action control, 0x10 match value, 0x14 pin control, 0x18 pulse length, 0x1C cause.
- R2: The counter adds one on each cycle where control bit 0 (run) is 1 and `tick_en` is 1, unless it is frozen. Otherwise it holds its value.
- R3: While control bit 1 is 1, the counter reads 0 from the cycle after that bit was written.
- R4: When control bit 2 is 1 and `dbg_halt` is 1, the counter holds its value even while ticking.
- R5: A match is the first cycle in which run is 1 and the counter equals the match value. A match sets flag bit 0, and writing 1 to that bit clears it. `irq` is flag AND action bit 0. If a match and a clearing write fall in the same cycle, the flag stays set.
- R6: With action bit 2 set, a match clears the counter to 0 and clears control bit 0.
- R7: With action bit 3 set, a match drives `int_rst_req` high in the next cycle.
- R8: With action bit 4 set, a match drives `ext_rst_n` low for (pulse length + 6) cycles in which `tick_en` is high. The pulse length field is 16 bits.
- R9: Action bit 5 raises `int_rst_req`, and action bit 6 starts the external pulse, without a match.
- R10: Pin control bit 0 is the `match_out` level and can be written directly. On a match, bits [5:4] act on that level: 0 keeps it, 1 drives it low, 2 drives it high, 3 inverts it.
- R11: Cause bit 0 is read-only. It is set when either reset request is issued, it survives `rst_n`, and only `por_n` clears it.
- R12: Writing 0 to the control register stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| por_n | input | 1 | Active-low power-on reset, clears the cause flag |
| tick_en | input | 1 | Counter tick enable |
| dbg_halt | input | 1 | Debug halt, freezes the counter when enabled |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Match interrupt |
| match_out | output | 1 | Match output pin level |
| int_rst_req | output | 1 | Internal reset request |
| ext_rst_n | output | 1 | Active-low external reset pulse |

## Verification
The match flag can be set by the hardware and cleared by a software write-one in the same cycle. The bench provokes this by stepping the counter tick by tick until it lands on the match value. It then issues the write-one to the flag in the very cycle the match is detected. The flag must read 1 afterwards, and a later clearing write must read 0, which shows the set beat the clear and did not merely miss the write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [2:0] {
    IDX_FLAG  = 3'd0,
    IDX_CTRL  = 3'd1,
    IDX_CNT   = 3'd2,
    IDX_ACT   = 3'd3,
    IDX_MATCH = 3'd4,
    IDX_PIN   = 3'd5,
    IDX_PULSE = 3'd6,
    IDX_CAUSE = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  // New pin level after a match, given the current level and the action code.
  function automatic logic pin_after_match(input logic lvl, input logic [1:0] act);
    case (pin_act_e'(act))
      PIN_KEEP: return lvl;
      PIN_LOW:  return 1'b0;
      PIN_HIGH: return 1'b1;
      default:  return ~lvl;
    endcase
  endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             freeze,
  input  logic             dbg_halt,
  input  logic             tick_en,
  input  logic             stop_on_match,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic             step
);

  logic eq_now;
  logic eq_q;

  // Equality is only a match in its first cycle, so a slow tick gives one event.
  assign eq_now = run && (cnt == match_val);
  assign hit    = eq_now && !eq_q;
  assign step   = run && tick_en && !(freeze && dbg_halt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      eq_q <= 1'b0;
    end else begin
      eq_q <= eq_now;
      if (clr)
        cnt <= '0;
      else if (hit && stop_on_match)
        cnt <= '0;
      else if (step)
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN_W = 16,
  parameter int EXTRA = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             active,
  output logic             start
);

  localparam int RW = LEN_W + 1;

  // Low time in ticks: the programmed length plus a fixed overhead.
  function automatic logic [RW-1:0] low_ticks(input logic [LEN_W-1:0] l);
    return RW'(l) + RW'(EXTRA);
  endfunction

  logic [RW-1:0] remain;

  assign start = trig && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start) begin
      active <= 1'b1;
      remain <= low_ticks(len);
    end else if (active && tick_en) begin
      if (remain <= RW'(1)) begin
        active <= 1'b0;
        remain <= '0;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/match_watchdog.sv
module match_watchdog #(
  parameter int CNT_W       = 32,
  parameter int PULSE_W     = 16,
  parameter int PULSE_EXTRA = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        tick_en,
  input  logic        dbg_halt,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        match_out,
  output logic        int_rst_req,
  output logic        ext_rst_n
);
  import wdt_pkg::*;

  localparam int ACT_W = 7;

  reg_idx_e           idx;
  logic               ctrl_run, ctrl_clr, ctrl_frz;
  logic [ACT_W-1:0]   act_q;
  logic [CNT_W-1:0]   match_val;
  logic [CNT_W-1:0]   cnt;
  logic               pin_lvl;
  logic [1:0]         pin_act;
  logic [PULSE_W-1:0] pulse_len;
  logic               flag_q, cause_q, int_req_q;
  logic               hit, step;
  logic               int_trig, ext_trig, pulse_active, pulse_start;

  assign idx = reg_idx_e'(bus_addr[4:2]);

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_run), .clr(ctrl_clr), .freeze(ctrl_frz),
    .dbg_halt(dbg_halt), .tick_en(tick_en), .stop_on_match(act_q[2]),
    .match_val(match_val), .cnt(cnt), .hit(hit), .step(step)
  );

  assign int_trig = (hit && act_q[3]) || act_q[5];
  assign ext_trig = (hit && act_q[4]) || act_q[6];

  wdt_pulse #(.LEN_W(PULSE_W), .EXTRA(PULSE_EXTRA)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trig(ext_trig),
    .len(pulse_len), .active(pulse_active), .start(pulse_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_run  <= 1'b0;
      ctrl_clr  <= 1'b0;
      ctrl_frz  <= 1'b0;
      act_q     <= '0;
      match_val <= '0;
      pin_lvl   <= 1'b0;
      pin_act   <= 2'd0;
      pulse_len <= '0;
      flag_q    <= 1'b0;
      int_req_q <= 1'b0;
    end else begin
      int_req_q <= int_trig;
      if (bus_wr && idx == IDX_CTRL) begin
        ctrl_run <= bus_wdata[0];
        ctrl_clr <= bus_wdata[1];
        ctrl_frz <= bus_wdata[2];
      end
      if (hit && act_q[2]) ctrl_run <= 1'b0;
      if (bus_wr && idx == IDX_ACT)   act_q     <= bus_wdata[ACT_W-1:0];
      if (bus_wr && idx == IDX_MATCH) match_val <= bus_wdata[CNT_W-1:0];
      if (bus_wr && idx == IDX_PULSE) pulse_len <= bus_wdata[PULSE_W-1:0];
      if (bus_wr && idx == IDX_PIN) begin
        pin_lvl <= bus_wdata[0];
        pin_act <= bus_wdata[5:4];
      end
      if (hit) pin_lvl <= pin_after_match(pin_lvl, pin_act);
      if (bus_wr && idx == IDX_FLAG && bus_wdata[0]) flag_q <= 1'b0;
      if (hit) flag_q <= 1'b1;
    end
  end

  // Cause flag lives in the power-on domain so it survives the system reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cause_q <= 1'b0;
    else if (int_trig || ext_trig)
      cause_q <= 1'b1;
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_FLAG:  bus_rdata[0] = flag_q;
      IDX_CTRL:  bus_rdata[2:0] = {ctrl_frz, ctrl_clr, ctrl_run};
      IDX_CNT:   bus_rdata[CNT_W-1:0] = cnt;
      IDX_ACT:   bus_rdata[ACT_W-1:0] = act_q;
      IDX_MATCH: bus_rdata[CNT_W-1:0] = match_val;
      IDX_PIN:   bus_rdata[5:0] = {pin_act, 3'b000, pin_lvl};
      IDX_PULSE: bus_rdata[PULSE_W-1:0] = pulse_len;
      default:   bus_rdata[0] = cause_q;
    endcase
  end

  assign irq         = flag_q && act_q[0];
  assign match_out   = pin_lvl;
  assign int_rst_req = int_req_q;
  assign ext_rst_n   = ~pulse_active;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             hit,
  input logic             step,
  input logic             clr,
  input logic             stop_on_match,
  input logic             mres_int,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             int_rst_req,
  input logic             ext_rst_n,
  input logic             cause
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr && !(hit && stop_on_match)) |=> $stable(cnt));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !(hit && stop_on_match)) |=> (cnt - $past(cnt)) == CNT_W'(1));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && stop_on_match) |=> (cnt == '0 && !run));

  assert_int_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mres_int) |=> int_rst_req);

  assert_pulse_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_rst_n) |=> !ext_rst_n);

  assert_cause_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!ext_rst_n || int_rst_req) |-> cause);

endmodule

bind match_watchdog wdt_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .hit(hit), .step(step),
  .clr(ctrl_clr), .stop_on_match(act_q[2]), .mres_int(act_q[3]),
  .run(ctrl_run), .cnt(cnt), .flag(flag_q), .int_rst_req(int_rst_req),
  .ext_rst_n(ext_rst_n), .cause(cause_q)
);

// File: tb/match_watchdog_bench.sv
`timescale 1ns/1ps
module match_watchdog_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, match_out, int_rst_req, ext_rst_n;

  int errors = 0;
  int checks = 0;
  int ext_low_total = 0;
  int int_req_total = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_FLAG = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08, A_ACT = 5'h0C,
                         A_MATCH = 5'h10, A_PIN = 5'h14, A_PULSE = 5'h18, A_CAUSE = 5'h1C;

  // {action[1:0], initial level, expected level after a match}
  localparam logic [3:0] PIN_VEC [8] = '{
    4'b0000, 4'b0011, 4'b0100, 4'b0110, 4'b1001, 4'b1011, 4'b1101, 4'b1110
  };

  always #2.5 clk = ~clk;

  match_watchdog u_match_watchdog (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .match_out(match_out), .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n)
  );

  always @(posedge clk) begin
    if (!ext_rst_n) ext_low_total++;
    if (int_rst_req) int_req_total++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick_n(input int k);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (k) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 ext_rst_n idle", {31'b0, ext_rst_n}, 32'h1);
    chk("R1 outputs idle", {29'b0, irq, match_out, int_rst_req}, 32'h0);

    // R2 exact tick count
    wr(A_MATCH, 32'hFFFF_0000);
    wr(A_CTRL, 32'h1);
    tick_n(13);
    rd(A_CNT, v);
    chk("R2 count equals ticks", v, 32'd13);

    // R12 stop by writing zero
    wr(A_CTRL, 32'h0);
    tick_n(10);
    rd(A_CNT, v);
    chk("R12 stopped counter holds", v, 32'd13);

    // R3 clear request
    wr(A_CTRL, 32'h2);
    rd(A_CNT, v);
    chk("R3 counter cleared", v, 32'd0);

    // R4 debug freeze
    wr(A_CTRL, 32'h5);
    dbg_halt = 1'b1;
    tick_n(10);
    rd(A_CNT, v);
    chk("R4 frozen under debug", v, 32'd0);
    dbg_halt = 1'b0;
    tick_n(7);
    rd(A_CNT, v);
    chk("R4 resumes after debug", v, 32'd7);

    // R5 flag, irq, write-one clear
    wr(A_CTRL, 32'h2);
    wr(A_MATCH, 32'd20);
    wr(A_ACT, 32'h1);
    tick_en = 1'b1;
    wr(A_CTRL, 32'h1);
    repeat (40) @(negedge clk);
    rd(A_FLAG, v);
    chk("R5 flag set on match", v, 32'h1);
    chk("R5 irq raised", {31'b0, irq}, 32'h1);
    wr(A_FLAG, 32'h1);
    rd(A_FLAG, v);
    chk("R5 flag cleared by write-one", v, 32'h0);
    chk("R5 irq dropped", {31'b0, irq}, 32'h0);

    // R5 set and clear in the same cycle: set wins
    tick_en = 1'b0;
    wr(A_CTRL, 32'h2);
    wr(A_MATCH, 32'd9);
    wr(A_CTRL, 32'h1);
    tick_n(9);
    bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_FLAG, v);
    chk("R5 match beats same-cycle clear", v, 32'h1);
    wr(A_FLAG, 32'h1);
    rd(A_FLAG, v);
    chk("R5 later clear works", v, 32'h0);

    // R6 stop on match
    wr(A_CTRL, 32'h2);
    wr(A_ACT, 32'h4);
    wr(A_MATCH, 32'd30);
    tick_en = 1'b1;
    wr(A_CTRL, 32'h1);
    repeat (60) @(negedge clk);
    rd(A_CNT, v);
    chk("R6 counter cleared on match", v, 32'd0);
    rd(A_CTRL, v);
    chk("R6 run bit cleared", v & 32'h1, 32'h0);

    // R7 internal reset on match, R11 cause
    snap = int_req_total;
    wr(A_CTRL, 32'h2);
    wr(A_ACT, 32'h8 | 32'h4);
    wr(A_MATCH, 32'd10);
    wr(A_CTRL, 32'h1);
    repeat (30) @(negedge clk);
    chk("R7 one internal request", 32'(int_req_total - snap), 32'd1);
    rd(A_CAUSE, v);
    chk("R11 cause set", v, 32'h1);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v);
    chk("R11 cause read-only", v, 32'h1);

    // R11 survives system reset, cleared by power-on reset
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    rd(A_CAUSE, v);
    chk("R11 cause survives rst_n", v, 32'h1);
    rd(A_ACT, v);
    chk("R1 action reg cleared by rst_n", v, 32'h0);
    @(negedge clk); rst_n = 1'b0; por_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1; por_n = 1'b1;
    rd(A_CAUSE, v);
    chk("R11 cause cleared by por_n", v, 32'h0);

    // R8 external pulse on match, two lengths including zero
    for (int n = 0; n < 2; n++) begin
      logic [31:0] len;
      len = (n == 0) ? 32'd3 : 32'd0;
      snap = ext_low_total;
      wr(A_CTRL, 32'h2);
      wr(A_PULSE, len);
      wr(A_ACT, 32'h10 | 32'h4);
      wr(A_MATCH, 32'd8);
      wr(A_CTRL, 32'h1);
      repeat (50) @(negedge clk);
      chk("R8 pulse low cycles", 32'(ext_low_total - snap), len + 32'd6);
    end

    // R9 forced resets
    wr(A_ACT, 32'h0);
    snap = int_req_total;
    wr(A_ACT, 32'h20);
    wr(A_ACT, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 forced internal request", {31'b0, (int_req_total - snap) > 0}, 32'h1);
    snap = ext_low_total;
    wr(A_PULSE, 32'd2);
    wr(A_ACT, 32'h40);
    wr(A_ACT, 32'h0);
    repeat (30) @(negedge clk);
    chk("R9 forced external pulse", 32'(ext_low_total - snap), 32'd8);

    // R10 pin actions from the vector table
    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, 32'h2);
      wr(A_ACT, 32'h4);
      wr(A_PIN, {26'b0, PIN_VEC[i][3:2], 3'b000, PIN_VEC[i][1]});
      wr(A_MATCH, 32'd5);
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      rd(A_PIN, v);
      chk("R10 pin level after match", v & 32'h1, {31'b0, PIN_VEC[i][0]});
      chk("R10 match_out port", {31'b0, match_out}, {31'b0, PIN_VEC[i][0]});
    end
    wr(A_PIN, 32'h1);
    chk("R10 direct pin write", {31'b0, match_out}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule